// File: doc/BRIEF.md
# Link Channel State Registers with Non-Destructive Debug Rotate

This block keeps the working state of a group of serial-link DMA channels. Every link has an input channel and an output channel. Each channel holds three 32-bit registers: the most recent data byte, a pointer to the current location of the message in memory, and a byte count. A link-side strobe interface models message traffic. A start strobe loads the pointer and the count. A byte strobe stores the byte, advances the pointer and decrements the count.

A debug port lets a processor read a channel's state without destroying it. The processor side is modelled as a three-entry operand stack (A, B, C). A debug access takes the channel address from A and a value n from B. It returns the channel's data register in A and moves C into B. In the same cycle the channel's registers rotate one place: the pointer goes into data, the count goes into the pointer, and n goes into the count. The first access may use any n. If each later access passes the value returned by the previous one, four accesses bring the whole channel state out and leave the channel as it was.

The port is meant for quiescent channels. If link traffic hits the channel being accessed in the same cycle, the link update takes priority and a sticky collision flag is raised.

Top module: `link_chan_rotate`

## Requirements
- R1: Synchronous reset clears all channel registers, all three stack entries and the collision flag to zero.
- R2: A debug access puts the addressed channel's data register value from before the access into stack A and copies stack C into stack B. Stack C is unchanged.
- R3: On a debug access without collision, the addressed channel loads data from pointer, pointer from count, and count from stack B. All other channels are unchanged.
- R4: Four back-to-back accesses to one channel restore it exactly when each access after the first supplies, as n, the value returned by the access before it.
- R5: A link start strobe loads the chosen channel's pointer and count from the link inputs and leaves its data register unchanged.
- R6: A link byte strobe stores the zero-extended byte in data, adds one to the pointer and subtracts one from the count. If start and byte strobes arrive in the same cycle, only the start takes effect.
- R7: A byte strobe on a channel whose count is zero (an input channel with no local input started) leaves the count at all ones (-1).
- R8: If a debug access and a link strobe address the same channel in one cycle, only the link update is applied to that channel. Stack A still receives the old data value, and the collision flag is set on the next cycle.
- R9: The collision flag stays set until the clear input is asserted. If set and clear happen in the same cycle, set wins.
- R10: The stack-load strobe writes A, B and C from the stack inputs. A debug access in the same cycle takes priority, and the load is ignored.
- R11: The channel index is {link number, direction}, with bit 0 = 0 for the input channel and 1 for the output channel. The debug address is taken from the low index bits of stack A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stackLoad | input | 1 | Load the operand stack from stkAIn/stkBIn/stkCIn |
| stkAIn | input | 32 | Value for stack A |
| stkBIn | input | 32 | Value for stack B |
| stkCIn | input | 32 | Value for stack C |
| dbgAccess | input | 1 | Perform one debug rotate access |
| linkStart | input | 1 | Message start on linkChan |
| linkByte | input | 1 | One byte transferred on linkChan |
| linkChan | input | 3 | Channel index for the link strobes |
| linkPtr | input | 32 | Pointer loaded on message start |
| linkCount | input | 32 | Count loaded on message start |
| linkData | input | 8 | Byte stored on a byte strobe |
| clrCollision | input | 1 | Clear the collision flag |
| stkA | output | 32 | Stack entry A |
| stkB | output | 32 | Stack entry B |
| stkC | output | 32 | Stack entry C |
| collision | output | 1 | Sticky debug/link collision flag |

## Verification
The properties assume that linkChan always names an existing channel and that the debug address is read from the low bits of stack A as it stands in the access cycle. They also assume that a stack load and an access in the same cycle resolve in favour of the access. The stimulus only drives channel indices below the channel count. It sets up the stack one cycle before each access, except in the single directed case that tests the load/access priority. The stimulus keeps link traffic away from a channel while a four-access read of that channel is in progress. The only exceptions are the deliberate collision cases, which check the flag and the link-wins result.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  localparam int CHAN_IDX_W = 8;

  typedef struct packed {
    logic                  stackShift;
    logic                  stackLoad;
    logic [CHAN_IDX_W-1:0] readChan;
    logic                  rotEn;
    logic                  startEn;
    logic                  byteEn;
    logic [CHAN_IDX_W-1:0] linkChan;
  } lcrStrobes_t;

endpackage

// File: rtl/lcr_ctrl.sv
module lcr_ctrl
  import lcr_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbgAccess,
  input  logic            stackLoad,
  input  logic            linkStart,
  input  logic            linkByte,
  input  logic [CH_W-1:0] linkChan,
  input  logic [CH_W-1:0] dbgAddr,
  input  logic            clrCollision,
  output lcrStrobes_t     strb,
  output logic            collision
);

  logic linkEvent;
  logic sameChan;
  logic clash;

  assign linkEvent = linkStart | linkByte;
  assign sameChan  = (linkChan == dbgAddr);
  assign clash     = dbgAccess & linkEvent & sameChan;

  always_comb begin
    strb            = '0;
    strb.stackShift = dbgAccess;
    strb.stackLoad  = stackLoad & ~dbgAccess;
    strb.readChan   = CHAN_IDX_W'(dbgAddr);
    strb.rotEn      = dbgAccess & ~clash;
    strb.startEn    = linkStart;
    strb.byteEn     = linkByte & ~linkStart;
    strb.linkChan   = CHAN_IDX_W'(linkChan);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collision <= 1'b0;
    end else if (clash) begin
      collision <= 1'b1;
    end else if (clrCollision) begin
      collision <= 1'b0;
    end
  end

endmodule

// File: rtl/lcr_datapath.sv
module lcr_datapath
  import lcr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lcrStrobes_t       strb,
  input  logic [DATA_W-1:0] stkAIn,
  input  logic [DATA_W-1:0] stkBIn,
  input  logic [DATA_W-1:0] stkCIn,
  input  logic [DATA_W-1:0] linkPtr,
  input  logic [DATA_W-1:0] linkCount,
  input  logic [BYTE_W-1:0] linkData,
  output logic [DATA_W-1:0] stkA,
  output logic [DATA_W-1:0] stkB,
  output logic [DATA_W-1:0] stkC
);

  logic [DATA_W-1:0] dataReg [NUM_CH];
  logic [DATA_W-1:0] ptrReg  [NUM_CH];
  logic [DATA_W-1:0] cntReg  [NUM_CH];
  logic [DATA_W-1:0] readVal;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic linkHit;
    logic rotHit;
    assign linkHit = (strb.linkChan == CHAN_IDX_W'(ch));
    assign rotHit  = strb.rotEn && (strb.readChan == CHAN_IDX_W'(ch));

    always_ff @(posedge clk) begin
      if (rst) begin
        dataReg[ch] <= '0;
        ptrReg[ch]  <= '0;
        cntReg[ch]  <= '0;
      end else if (strb.startEn && linkHit) begin
        ptrReg[ch]  <= linkPtr;
        cntReg[ch]  <= linkCount;
      end else if (strb.byteEn && linkHit) begin
        dataReg[ch] <= DATA_W'(linkData);
        ptrReg[ch]  <= ptrReg[ch] + DATA_W'(1);
        cntReg[ch]  <= cntReg[ch] - DATA_W'(1);
      end else if (rotHit) begin
        dataReg[ch] <= ptrReg[ch];
        ptrReg[ch]  <= cntReg[ch];
        cntReg[ch]  <= stkB;
      end
    end
  end

  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (strb.readChan == CHAN_IDX_W'(i)) readVal = dataReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stkA <= '0;
      stkB <= '0;
      stkC <= '0;
    end else if (strb.stackShift) begin
      stkA <= readVal;
      stkB <= stkC;
    end else if (strb.stackLoad) begin
      stkA <= stkAIn;
      stkB <= stkBIn;
      stkC <= stkCIn;
    end
  end

endmodule

// File: rtl/link_chan_rotate.sv
module link_chan_rotate
  import lcr_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              stackLoad,
  input  logic [DATA_W-1:0]                 stkAIn,
  input  logic [DATA_W-1:0]                 stkBIn,
  input  logic [DATA_W-1:0]                 stkCIn,
  input  logic                              dbgAccess,
  input  logic                              linkStart,
  input  logic                              linkByte,
  input  logic [$clog2(2*NUM_LINKS)-1:0]    linkChan,
  input  logic [DATA_W-1:0]                 linkPtr,
  input  logic [DATA_W-1:0]                 linkCount,
  input  logic [BYTE_W-1:0]                 linkData,
  input  logic                              clrCollision,
  output logic [DATA_W-1:0]                 stkA,
  output logic [DATA_W-1:0]                 stkB,
  output logic [DATA_W-1:0]                 stkC,
  output logic                              collision
);

  localparam int NUM_CH = 2 * NUM_LINKS;
  localparam int CH_W   = $clog2(NUM_CH);

  lcrStrobes_t strb;

  lcr_ctrl #(.CH_W(CH_W)) uCtrl (
    .clk          (clk),
    .rst          (rst),
    .dbgAccess    (dbgAccess),
    .stackLoad    (stackLoad),
    .linkStart    (linkStart),
    .linkByte     (linkByte),
    .linkChan     (linkChan),
    .dbgAddr      (stkA[CH_W-1:0]),
    .clrCollision (clrCollision),
    .strb         (strb),
    .collision    (collision)
  );

  lcr_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .stkAIn    (stkAIn),
    .stkBIn    (stkBIn),
    .stkCIn    (stkCIn),
    .linkPtr   (linkPtr),
    .linkCount (linkCount),
    .linkData  (linkData),
    .stkA      (stkA),
    .stkB      (stkB),
    .stkC      (stkC)
  );

endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
  parameter int CH_W   = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              dbgAccess,
  input logic              stackLoad,
  input logic              linkStart,
  input logic              linkByte,
  input logic [CH_W-1:0]   linkChan,
  input logic [CH_W-1:0]   addr,
  input logic [DATA_W-1:0] stkAIn,
  input logic [DATA_W-1:0] stkA,
  input logic [DATA_W-1:0] stkB,
  input logic [DATA_W-1:0] stkC,
  input logic              clrCollision,
  input logic              collision
);

  // R2: access moves C into B and leaves C alone
  assert_stack_shift_R2: assert property (@(posedge clk) disable iff (rst)
    dbgAccess |=> (stkB == $past(stkC)) && (stkC == $past(stkC)));

  // R8: a same-channel link strobe during an access raises the flag
  assert_collision_set_R8: assert property (@(posedge clk) disable iff (rst)
    (dbgAccess && (linkStart || linkByte) && (linkChan == addr)) |=> collision);

  // R9: flag is sticky without a clear
  assert_collision_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (collision && !clrCollision) |=> collision);

  // R9: clear without a new clash drops the flag
  assert_collision_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clrCollision && !(dbgAccess && (linkStart || linkByte) && (linkChan == addr)))
      |=> !collision);

  // R10: load without access writes stack A
  assert_stack_load_R10: assert property (@(posedge clk) disable iff (rst)
    (stackLoad && !dbgAccess) |=> (stkA == $past(stkAIn)));

endmodule

bind link_chan_rotate lcr_checker #(.CH_W(CH_W), .DATA_W(DATA_W)) uChk (
  .clk          (clk),
  .rst          (rst),
  .dbgAccess    (dbgAccess),
  .stackLoad    (stackLoad),
  .linkStart    (linkStart),
  .linkByte     (linkByte),
  .linkChan     (linkChan),
  .addr         (stkA[CH_W-1:0]),
  .stkAIn       (stkAIn),
  .stkA         (stkA),
  .stkB         (stkB),
  .stkC         (stkC),
  .clrCollision (clrCollision),
  .collision    (collision)
);

// File: tb/tb_link_chan_rotate.sv
module tb_link_chan_rotate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stackLoad = 1'b0;
  logic [31:0] stkAIn = '0, stkBIn = '0, stkCIn = '0;
  logic        dbgAccess = 1'b0;
  logic        linkStart = 1'b0, linkByte = 1'b0;
  logic [2:0]  linkChan = '0;
  logic [31:0] linkPtr = '0, linkCount = '0;
  logic [7:0]  linkData = '0;
  logic        clrCollision = 1'b0;
  logic [31:0] stkA, stkB, stkC;
  logic        collision;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_chan_rotate dut (
    .clk(clk), .rst(rst), .stackLoad(stackLoad), .stkAIn(stkAIn),
    .stkBIn(stkBIn), .stkCIn(stkCIn), .dbgAccess(dbgAccess),
    .linkStart(linkStart), .linkByte(linkByte), .linkChan(linkChan),
    .linkPtr(linkPtr), .linkCount(linkCount), .linkData(linkData),
    .clrCollision(clrCollision), .stkA(stkA), .stkB(stkB), .stkC(stkC),
    .collision(collision)
  );

  // kind: 0 start (a=ptr, b=count), 1 byte (a=data), 2 access (a=n, b=expected A)
  localparam int NV = 28;
  localparam logic [68:0] VEC [NV] = '{
    {2'd0, 3'd2, 32'h100,  32'd3},
    {2'd1, 3'd2, 32'hAA,   32'd0},
    {2'd1, 3'd2, 32'hBB,   32'd0},
    {2'd0, 3'd5, 32'h2000, 32'd5},
    {2'd1, 3'd5, 32'h11,   32'd0},
    {2'd2, 3'd2, 32'h0,    32'hBB},
    {2'd2, 3'd2, 32'hBB,   32'h102},
    {2'd2, 3'd2, 32'h102,  32'h1},
    {2'd2, 3'd2, 32'h1,    32'h0},
    {2'd2, 3'd5, 32'h0,    32'h11},
    {2'd2, 3'd5, 32'h11,   32'h2001},
    {2'd2, 3'd5, 32'h2001, 32'h4},
    {2'd2, 3'd5, 32'h4,    32'h0},
    {2'd1, 3'd6, 32'h5A,   32'd0},
    {2'd2, 3'd6, 32'h0,    32'h5A},
    {2'd2, 3'd6, 32'h5A,   32'h1},
    {2'd2, 3'd6, 32'h1,    32'hFFFF_FFFF},
    {2'd2, 3'd6, 32'hFFFF_FFFF, 32'h0},
    {2'd2, 3'd0, 32'h0,    32'h0},
    {2'd2, 3'd2, 32'h0,    32'hBB},
    {2'd2, 3'd2, 32'hBB,   32'h102},
    {2'd2, 3'd2, 32'h102,  32'h1},
    {2'd2, 3'd2, 32'h1,    32'h0},
    {2'd1, 3'd5, 32'h22,   32'd0},
    {2'd2, 3'd5, 32'h0,    32'h22},
    {2'd2, 3'd5, 32'h22,   32'h2002},
    {2'd2, 3'd5, 32'h2002, 32'h3},
    {2'd2, 3'd5, 32'h3,    32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStart(input logic [2:0] ch, input logic [31:0] p, input logic [31:0] c);
    @(negedge clk);
    linkStart = 1'b1; linkChan = ch; linkPtr = p; linkCount = c;
    @(negedge clk);
    linkStart = 1'b0;
  endtask

  task automatic doByte(input logic [2:0] ch, input logic [7:0] d);
    @(negedge clk);
    linkByte = 1'b1; linkChan = ch; linkData = d;
    @(negedge clk);
    linkByte = 1'b0;
  endtask

  task automatic loadStack(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    stackLoad = 1'b1; stkAIn = a; stkBIn = b; stkCIn = c;
    @(negedge clk);
    stackLoad = 1'b0;
  endtask

  task automatic doAccess(input logic [2:0] ch, input logic [31:0] n, output logic [31:0] res);
    loadStack({29'd0, ch}, n, 32'h0);
    dbgAccess = 1'b1;
    @(negedge clk);
    dbgAccess = 1'b0;
    res = stkA;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 stkA", stkA, 32'h0);
    chk("R1 stkB", stkB, 32'h0);
    chk("R1 stkC", stkC, 32'h0);
    chk("R1 collision", {31'd0, collision}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  kind;
      logic [2:0]  ch;
      logic [31:0] a, b;
      {kind, ch, a, b} = VEC[i];
      case (kind)
        2'd0: doStart(ch, a, b);
        2'd1: doByte(ch, a[7:0]);
        default: begin
          doAccess(ch, a, r);
          chk("R3/R4/R5/R6/R7/R11 table read", r, b);
        end
      endcase
    end

    // R2: C moves into B, C stays, A gets old data of ch3 (zero)
    loadStack(32'd3, 32'h55, 32'hC0FFEE);
    dbgAccess = 1'b1;
    @(negedge clk);
    dbgAccess = 1'b0;
    chk("R2 stkA", stkA, 32'h0);
    chk("R2 stkB", stkB, 32'hC0FFEE);
    chk("R2 stkC", stkC, 32'hC0FFEE);

    // R6: start and byte in one cycle -> start only
    @(negedge clk);
    linkStart = 1'b1; linkByte = 1'b1; linkChan = 3'd3;
    linkPtr = 32'h40; linkCount = 32'd9; linkData = 8'hCC;
    @(negedge clk);
    linkStart = 1'b0; linkByte = 1'b0;
    doAccess(3'd3, 32'h0, r);  chk("R6 priority data", r, 32'h0);
    doAccess(3'd3, r, r);      chk("R6 priority ptr", r, 32'h40);
    doAccess(3'd3, r, r);      chk("R6 priority count", r, 32'd9);

    // R8: collision on ch7
    doStart(3'd7, 32'h300, 32'd2);
    loadStack(32'd7, 32'h999, 32'h0);
    dbgAccess = 1'b1; linkByte = 1'b1; linkChan = 3'd7; linkData = 8'hEE;
    @(negedge clk);
    dbgAccess = 1'b0; linkByte = 1'b0;
    chk("R8 stkA old data", stkA, 32'h0);
    chk("R8 flag set", {31'd0, collision}, 32'h1);
    doAccess(3'd7, 32'h0, r);  chk("R8 link wins data", r, 32'hEE);
    doAccess(3'd7, r, r);      chk("R8 link wins ptr", r, 32'h301);
    doAccess(3'd7, r, r);      chk("R8 link wins count", r, 32'h1);

    // R9: sticky, clear, set beats clear
    chk("R9 sticky", {31'd0, collision}, 32'h1);
    @(negedge clk); clrCollision = 1'b1;
    @(negedge clk); clrCollision = 1'b0;
    chk("R9 cleared", {31'd0, collision}, 32'h0);
    loadStack(32'd7, 32'h0, 32'h0);
    dbgAccess = 1'b1; linkByte = 1'b1; linkChan = 3'd7; clrCollision = 1'b1;
    @(negedge clk);
    dbgAccess = 1'b0; linkByte = 1'b0; clrCollision = 1'b0;
    chk("R9 set beats clear", {31'd0, collision}, 32'h1);
    @(negedge clk); clrCollision = 1'b1;
    @(negedge clk); clrCollision = 1'b0;
    loadStack(32'd4, 32'h0, 32'h0);
    dbgAccess = 1'b1; linkByte = 1'b1; linkChan = 3'd7;
    @(negedge clk);
    dbgAccess = 1'b0; linkByte = 1'b0;
    chk("R8 different channel no flag", {31'd0, collision}, 32'h0);

    // R10: access beats load; ch2 data is BB
    loadStack(32'd2, 32'h1, 32'h1234);
    stackLoad = 1'b1; dbgAccess = 1'b1;
    stkAIn = 32'hDEAD; stkBIn = 32'hBEEF; stkCIn = 32'hF00D;
    @(negedge clk);
    stackLoad = 1'b0; dbgAccess = 1'b0;
    chk("R10 stkA from channel", stkA, 32'hBB);
    chk("R10 stkB from C", stkB, 32'h1234);
    chk("R10 stkC kept", stkC, 32'h1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule